// File: doc/BRIEF.md
# Automatic Cache Transfer Controller

This block keeps the bookkeeping for a small sector cache that sits between a disc data decoder and a host transfer engine. It holds three counters. The first counts decoded blocks that are ready in the cache. The second counts blocks the host has asked for and not yet received. The third is a skip value that drops cached blocks the host will not read. The block also keeps the 16-bit address of the next block to be sent to the host. The decoder signals each finished error check, and the host engine signals each finished block transfer. The counters and the address move on those events without firmware stepping in.

When the trigger enable is set and both the cached and the requested counts are non-zero, the block raises a transfer trigger. In the same edge it computes the burst size as the smallest of a programmable limit, the cached count and the requested count. If word counting is enabled, it also computes the byte count of the burst. The trigger stays high until the host engine has reported every block of that burst.

Top module: `cache_xfer_ctl`

## Requirements
- R1: An active-low asynchronous reset, a synchronous host clear and a synchronous firmware clear each zero the control register, all three counters, the block address, the trigger, the burst block count and the byte count.
- R2: Register writes use `wr_sel` to pick the target: 0 control, 1 cached count, 2 skip, 3 requested count, 4 address low byte, 5 address high byte. The control byte is laid out as bit 7 trigger enable, bit 6 cache management enable, bit 5 increment enable and bits 4..0 the burst limit. A direct write to a counter takes priority over any event in the same cycle.
- R3: One clock edge after the trigger enable is high and both the cached and the requested counts are non-zero, `xfer_trig` goes high.
- R4: `xfer_trig` stays high through the first `burst_blks` block-done strobes. The strobe after those clears it at the next edge.
- R5: With management enabled, each block-done strobe adds 1 to the block address and subtracts 1 from the cached and the requested counts. Both counts stop at 0.
- R6: With management enabled, writing N to the skip register stores N, subtracts N from the cached count and adds N to the block address, all at the next edge. The cached count stops at 0, and the address wraps modulo 2^16.
- R7: When the trigger rises with management enabled, `burst_blks` is loaded with min(limit, cached, requested) − 1. A limit field of 0 means 32.
- R8: When the trigger rises and `wc_en` is high, `byte_cnt` is loaded with (burst_blks+1)·(words_per_blk+1)·2 modulo 2^16. When `wc_en` is low, `byte_cnt` keeps its value.
- R9: While management is disabled, the skip register and the requested count read 0 and ignore writes. Block-done strobes and skip writes leave the cached count and the address unchanged.
- R10: With the increment enable set, an error-check-done strobe adds 1 to the cached count, but only when neither `sta_err` nor `hdr_err` is high.
- R11: An increment and a decrement of the cached count in the same cycle cancel. An increment at 255 leaves the count at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clr | input | 1 | Synchronous clear from host reset |
| fw_clr | input | 1 | Synchronous clear from firmware reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| edc_done | input | 1 | End-of-error-check strobe |
| sta_err | input | 1 | Status error flag for the checked block |
| hdr_err | input | 1 | Header error flag for the checked block |
| blk_done | input | 1 | End-of-block-transfer strobe |
| wc_en | input | 1 | Enables the byte count computation |
| words_per_blk | input | 16 | Words per block minus one |
| ctrl_out | output | 8 | Control register value |
| cache_cnt | output | 8 | Cached block count |
| req_cnt | output | 8 | Requested block count |
| skip_val | output | 8 | Skip register value |
| blk_addr | output | 16 | Next host block address |
| xfer_trig | output | 1 | Automatic transfer trigger |
| burst_blks | output | 5 | Burst block count minus one |
| byte_cnt | output | 16 | Burst byte count |

## Verification
The burst computation is driven from a table of cases. In each case a different operand is the smallest: the limit, the cached count or the requested count. One case uses a zero limit to select 32, and one uses a byte product that wraps to zero. These cases show whether the minimum takes all three inputs and whether the limit decode is right. Directed sequences then separate the saturating, cancelling and clamping paths of the cached count from plain arithmetic. They also separate management-off holding from ordinary write behaviour, and the end-of-burst clearing of the trigger from an early or late release.

// File: rtl/cxc_pkg.sv
package cxc_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_CACHE   = 3'd1,
        SEL_SKIP    = 3'd2,
        SEL_REQ     = 3'd3,
        SEL_ADDR_LO = 3'd4,
        SEL_ADDR_HI = 3'd5
    } reg_sel_e;

    localparam int LIM_W = 5;

    typedef struct packed {
        logic             trig_en;
        logic             mgmt_en;
        logic             inc_en;
        logic [LIM_W-1:0] limit;
    } ctrl_t;

endpackage

// File: rtl/cxc_sat_counter.sv
module cxc_sat_counter #(
    parameter int WIDTH   = 8,
    parameter int SUBW    = 8,
    parameter bit HAS_INC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold_zero,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             inc,
    input  logic             dec,
    input  logic [SUBW-1:0]  sub,
    output logic [WIDTH-1:0] cnt
);
    localparam int AW = ((WIDTH > SUBW) ? WIDTH : SUBW) + 2;
    localparam logic [AW-1:0] MAXV = {{(AW-WIDTH){1'b0}}, {WIDTH{1'b1}}};

    logic [WIDTH-1:0] cnt_d, cnt_q;
    logic             inc_eff;
    logic [AW-1:0]    total, take, diff;

    assign inc_eff = HAS_INC ? inc : 1'b0;

    always_comb begin
        total = AW'(cnt_q) + AW'(inc_eff);
        take  = AW'(dec) + AW'(sub);
        diff  = total - take;
        if (clr || hold_zero) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (total >= take) begin
            cnt_d = (diff > MAXV) ? MAXV[WIDTH-1:0] : diff[WIDTH-1:0];
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R5
    zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold_zero && !load && dec && !inc_eff && sub == '0 && cnt_q == '0)
        |=> cnt_q == '0);

    // R11
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold_zero && !load && dec && inc_eff && sub == '0)
        |=> $stable(cnt_q));

endmodule

// File: rtl/cxc_burst_calc.sv
module cxc_burst_calc #(
    parameter int LIM_W  = 5,
    parameter int CNT_W  = 8,
    parameter int WPB_W  = 16,
    parameter int BYTE_W = 16
) (
    input  logic [LIM_W-1:0]  limit,
    input  logic [CNT_W-1:0]  cache_cnt,
    input  logic [CNT_W-1:0]  req_cnt,
    input  logic [WPB_W-1:0]  words_per_blk,
    output logic [LIM_W-1:0]  burst,
    output logic [BYTE_W-1:0] bytes
);
    localparam int MW = ((LIM_W + 1) > CNT_W) ? (LIM_W + 1) : CNT_W;
    localparam int PW = (LIM_W + 1) + (WPB_W + 1) + 1;

    logic [MW-1:0] lim_eff, m1, m2;
    logic [PW-1:0] prod;

    always_comb begin
        lim_eff = (limit == '0) ? MW'(1 << LIM_W) : MW'(limit);
        m1      = (lim_eff < MW'(cache_cnt)) ? lim_eff : MW'(cache_cnt);
        m2      = (m1 < MW'(req_cnt)) ? m1 : MW'(req_cnt);
        burst   = LIM_W'(m2 - MW'(1));
        prod    = PW'({1'b0, burst} + 1'b1) * PW'({1'b0, words_per_blk} + 1'b1);
        bytes   = BYTE_W'(prod << 1);
    end

endmodule

// File: rtl/cache_xfer_ctl.sv
module cache_xfer_ctl
    import cxc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int WPB_W  = 16,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_clr,
    input  logic              fw_clr,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              edc_done,
    input  logic              sta_err,
    input  logic              hdr_err,
    input  logic              blk_done,
    input  logic              wc_en,
    input  logic [WPB_W-1:0]  words_per_blk,
    output logic [7:0]        ctrl_out,
    output logic [CNT_W-1:0]  cache_cnt,
    output logic [CNT_W-1:0]  req_cnt,
    output logic [CNT_W-1:0]  skip_val,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              xfer_trig,
    output logic [LIM_W-1:0]  burst_blks,
    output logic [BYTE_W-1:0] byte_cnt
);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  skip;
        logic [ADDR_W-1:0] addr;
        logic              trig;
        logic [LIM_W-1:0]  rem;
        logic [LIM_W-1:0]  burst;
        logic [BYTE_W-1:0] bytes;
    } state_t;

    state_t st_d, st_q;

    logic soft_clr;
    logic wr_ctrl, wr_cache, wr_skip, wr_req, wr_lo, wr_hi;
    logic mgmt, skip_go, dec_go, inc_go, start;
    logic [CNT_W-1:0]  cache_q, req_q, skip_amt;
    logic [LIM_W-1:0]  calc_burst;
    logic [BYTE_W-1:0] calc_bytes;

    assign soft_clr = host_clr | fw_clr;
    assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
    assign wr_cache = wr_en && (wr_sel == SEL_CACHE);
    assign wr_skip  = wr_en && (wr_sel == SEL_SKIP);
    assign wr_req   = wr_en && (wr_sel == SEL_REQ);
    assign wr_lo    = wr_en && (wr_sel == SEL_ADDR_LO);
    assign wr_hi    = wr_en && (wr_sel == SEL_ADDR_HI);

    assign mgmt     = st_q.ctrl.mgmt_en;
    assign skip_go  = mgmt && wr_skip;
    assign skip_amt = skip_go ? CNT_W'(wr_data) : '0;
    assign dec_go   = mgmt && blk_done;
    assign inc_go   = st_q.ctrl.inc_en && edc_done && !sta_err && !hdr_err;
    assign start    = !st_q.trig && st_q.ctrl.trig_en && (cache_q != '0) && (req_q != '0);

    cxc_sat_counter #(.WIDTH(CNT_W), .SUBW(CNT_W), .HAS_INC(1'b1)) u_cache_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_clr),
        .hold_zero(1'b0),
        .load     (wr_cache),
        .load_val (CNT_W'(wr_data)),
        .inc      (inc_go),
        .dec      (dec_go),
        .sub      (skip_amt),
        .cnt      (cache_q)
    );

    cxc_sat_counter #(.WIDTH(CNT_W), .SUBW(CNT_W), .HAS_INC(1'b0)) u_req_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_clr),
        .hold_zero(!mgmt),
        .load     (wr_req),
        .load_val (CNT_W'(wr_data)),
        .inc      (1'b0),
        .dec      (dec_go),
        .sub      ('0),
        .cnt      (req_q)
    );

    cxc_burst_calc #(.LIM_W(LIM_W), .CNT_W(CNT_W), .WPB_W(WPB_W), .BYTE_W(BYTE_W)) u_burst (
        .limit        (st_q.ctrl.limit),
        .cache_cnt    (cache_q),
        .req_cnt      (req_q),
        .words_per_blk(words_per_blk),
        .burst        (calc_burst),
        .bytes        (calc_bytes)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(wr_data);

        if (!mgmt)        st_d.skip = '0;
        else if (wr_skip) st_d.skip = CNT_W'(wr_data);

        st_d.addr = st_q.addr + ADDR_W'(dec_go) + ADDR_W'(skip_amt);
        if (wr_lo) st_d.addr[7:0] = wr_data;
        if (wr_hi) st_d.addr[ADDR_W-1:8] = HI_W'(wr_data);

        if (start) begin
            st_d.trig = 1'b1;
            if (mgmt) begin
                st_d.burst = calc_burst;
                st_d.rem   = calc_burst;
                if (wc_en) st_d.bytes = calc_bytes;
            end else begin
                st_d.rem = st_q.burst;
            end
        end else if (st_q.trig && blk_done) begin
            if (st_q.rem == '0) st_d.trig = 1'b0;
            else                st_d.rem  = st_q.rem - 1'b1;
        end

        if (soft_clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_out   = st_q.ctrl;
    assign cache_cnt  = cache_q;
    assign req_cnt    = req_q;
    assign skip_val   = st_q.skip;
    assign blk_addr   = st_q.addr;
    assign xfer_trig  = st_q.trig;
    assign burst_blks = st_q.burst;
    assign byte_cnt   = st_q.bytes;

    // R3
    trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && !xfer_trig && st_q.ctrl.trig_en && cache_cnt != '0 && req_cnt != '0)
        |=> xfer_trig);

    // R7
    burst_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_trig) && $past(mgmt))
        |-> (CNT_W'(burst_blks) < $past(cache_cnt)) && (CNT_W'(burst_blks) < $past(req_cnt)));

    // R9
    mgmt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt && !$past(mgmt)) |-> (skip_val == '0 && req_cnt == '0));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && mgmt && blk_done && !wr_skip && !wr_lo && !wr_hi)
        |=> blk_addr == $past(blk_addr) + 1'b1);

endmodule

// File: tb/cache_xfer_ctl_test.sv
module cache_xfer_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_clr = 1'b0, fw_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        edc_done = 1'b0, sta_err = 1'b0, hdr_err = 1'b0, blk_done = 1'b0;
    logic        wc_en = 1'b0;
    logic [15:0] words_per_blk = '0;
    logic [7:0]  ctrl_out, cache_cnt, req_cnt, skip_val;
    logic [15:0] blk_addr, byte_cnt;
    logic        xfer_trig;
    logic [4:0]  burst_blks;

    int total = 0, bad = 0;
    bit done = 1'b0;

    localparam logic [7:0] TRG = 8'h80, MGT = 8'h40, INC = 8'h20;

    always #2 clk = ~clk;

    cache_xfer_ctl uut (
        .clk(clk), .rst_n(rst_n), .host_clr(host_clr), .fw_clr(fw_clr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .edc_done(edc_done), .sta_err(sta_err), .hdr_err(hdr_err), .blk_done(blk_done),
        .wc_en(wc_en), .words_per_blk(words_per_blk),
        .ctrl_out(ctrl_out), .cache_cnt(cache_cnt), .req_cnt(req_cnt), .skip_val(skip_val),
        .blk_addr(blk_addr), .xfer_trig(xfer_trig), .burst_blks(burst_blks), .byte_cnt(byte_cnt)
    );

    typedef struct packed {
        logic [4:0]  limit;
        logic [7:0]  cache;
        logic [7:0]  req;
        logic [15:0] wpb;
        logic [4:0]  exp_burst;
        logic [15:0] exp_bytes;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd4,  8'd10,  8'd20,  16'd1023, 5'd3,  16'd8192},
        '{5'd0,  8'd40,  8'd50,  16'd0,    5'd31, 16'd64},
        '{5'd31, 8'd3,   8'd9,   16'd1175, 5'd2,  16'd7056},
        '{5'd8,  8'd200, 8'd1,   16'd2047, 5'd0,  16'd4096},
        '{5'd1,  8'd5,   8'd5,   16'd9,    5'd0,  16'd20},
        '{5'd0,  8'd255, 8'd255, 16'd1023, 5'd31, 16'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic blk();
        blk_done = 1'b1;
        @(posedge clk); #1;
        blk_done = 1'b0;
    endtask

    task automatic edc(input logic se, input logic he);
        edc_done = 1'b1; sta_err = se; hdr_err = he;
        @(posedge clk); #1;
        edc_done = 1'b0; sta_err = 1'b0; hdr_err = 1'b0;
    endtask

    task automatic fwclr();
        fw_clr = 1'b1;
        @(posedge clk); #1;
        fw_clr = 1'b0;
    endtask

    task automatic arm(input logic [4:0] lim, input logic [7:0] c, input logic [7:0] r);
        fwclr();
        wr(3'd0, MGT | {3'b0, lim});
        wr(3'd1, c);
        wr(3'd3, r);
        wr(3'd0, TRG | MGT | {3'b0, lim});
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        // R1 reset state
        check("R1 ctrl", ctrl_out, 0);
        check("R1 cache", cache_cnt, 0);
        check("R1 trig", xfer_trig, 0);
        check("R1 addr", blk_addr, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R7 R8 table walk
        wc_en = 1'b1;
        foreach (VECS[i]) begin
            words_per_blk = VECS[i].wpb;
            arm(VECS[i].limit, VECS[i].cache, VECS[i].req);
            check("R3 trig", xfer_trig, 1);
            check("R7 burst", burst_blks, VECS[i].exp_burst);
            check("R8 bytes", byte_cnt, VECS[i].exp_bytes);
        end

        // R8 byte count kept when wc_en low
        wc_en = 1'b0;
        words_per_blk = 16'd1023;
        arm(5'd4, 8'd10, 8'd20);
        check("R8 hold bytes", byte_cnt, 0);
        check("R7 burst nowc", burst_blks, 3);

        // R4 R5 burst end
        wc_en = 1'b1;
        arm(5'd31, 8'd3, 8'd9);
        blk(); blk();
        check("R4 trig mid", xfer_trig, 1);
        blk();
        check("R4 trig end", xfer_trig, 0);
        check("R5 cache", cache_cnt, 0);
        check("R5 req", req_cnt, 6);
        check("R5 addr", blk_addr, 3);
        blk();
        check("R5 cache floor", cache_cnt, 0);
        check("R5 req after", req_cnt, 5);
        check("R4 no retrig", xfer_trig, 0);

        // R6 skip
        fwclr();
        wr(3'd0, MGT);
        wr(3'd1, 8'd10);
        wr(3'd2, 8'd4);
        check("R6 cache", cache_cnt, 6);
        check("R6 addr", blk_addr, 4);
        check("R6 skip", skip_val, 4);
        wr(3'd2, 8'd20);
        check("R6 clamp", cache_cnt, 0);
        check("R6 addr2", blk_addr, 24);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'hFF);
        check("R2 addr write", blk_addr, 16'hFFFE);
        wr(3'd2, 8'd5);
        check("R6 wrap", blk_addr, 16'h0003);

        // R10 increment gating
        wr(3'd0, MGT | INC);
        wr(3'd1, 8'd5);
        edc(1'b0, 1'b0);
        check("R10 inc", cache_cnt, 6);
        edc(1'b1, 1'b0);
        check("R10 sta_err", cache_cnt, 6);
        edc(1'b0, 1'b1);
        check("R10 hdr_err", cache_cnt, 6);

        // R11 cancel and ceiling
        wr(3'd3, 8'd4);
        edc_done = 1'b1; blk_done = 1'b1;
        @(posedge clk); #1;
        edc_done = 1'b0; blk_done = 1'b0;
        check("R11 cancel", cache_cnt, 6);
        check("R11 req dec", req_cnt, 3);
        wr(3'd1, 8'd255);
        edc(1'b0, 1'b0);
        check("R11 ceiling", cache_cnt, 255);

        // R2 write priority over event
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'd9; blk_done = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; blk_done = 1'b0;
        check("R2 priority", cache_cnt, 9);
        wr(3'd0, 8'h00);
        edc(1'b0, 1'b0);
        check("R10 inc off", cache_cnt, 9);

        // R9 management off
        fwclr();
        wr(3'd0, MGT);
        wr(3'd1, 8'd7);
        wr(3'd3, 8'd4);
        wr(3'd2, 8'd1);
        wr(3'd0, 8'h00);
        @(posedge clk); #1;
        check("R9 req zero", req_cnt, 0);
        check("R9 skip zero", skip_val, 0);
        blk();
        check("R9 cache kept", cache_cnt, 6);
        check("R9 addr kept", blk_addr, 1);
        wr(3'd2, 8'd3);
        check("R9 skip ignored", cache_cnt, 6);
        check("R9 skip read", skip_val, 0);
        wr(3'd3, 8'd9);
        check("R9 req ignored", req_cnt, 0);

        // R1 host clear
        wr(3'd0, MGT | INC);
        host_clr = 1'b1;
        @(posedge clk); #1;
        host_clr = 1'b0;
        check("R1 host ctrl", ctrl_out, 0);
        check("R1 host cache", cache_cnt, 0);
        check("R1 host addr", blk_addr, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule